// File: doc/BRIEF.md
# Boot Configuration Loader

This block runs once after reset and gathers the device identity and option bytes from three sources, trying them in a fixed order. First it reads a serial EEPROM over a three-wire bus that it drives itself: a clock, a chip select and a shared data line. It starts with the words that are covered by the checksum. If that checksum fails, it reads a 64-byte one-time-programmable fuse array through a synchronous byte port and checks that array's own checksum. If neither source passes, it uses constants built into the block.

Both checks use the same 8-bit sum. Bytes are added one at a time, and any carry out of bit 7 is added back into the result (an end-around carry). A stored checksum byte is correct when it equals 0xFF minus this sum. Once a source has been chosen, the loader writes all the fields together into output registers, reports which source was used, and raises `done_o`. The outputs then stay fixed until the next reset.

Top module: `boot_cfg_loader`

## Requirements
- R1: Each EEPROM word read sends a start bit 1, then the read opcode bits 1,0, then an 8-bit word address MSB first. The EEPROM then returns one dummy bit followed by 16 data bits, MSB first. Words are read in the order 03h, 04h, 05h, then 00h, 01h, 02h and the LED word 42h.
- R2: One serial clock period is CLK_DIV system clocks: a low half followed by a high half. Chip select rises while the clock is low, before the first rising edge. The outgoing data bit changes only while the clock is low. Incoming data is sampled at the end of the high half.
- R3: The clock and chip-select enable is high only while chip select is asserted. The data-line enable is high only during the 11 command bits. All enables are low during reset and after loading.
- R4: The EEPROM is accepted when the low byte of word 05h equals 0xFF minus the sum of the bytes of words 03h and 04h. When it is accepted, the outputs are set as follows: node address from words 00h–02h (each word's low byte is the earlier octet), vendor ID from word 03h, product ID from word 04h, flags from the high byte of word 05h, LED mode from word 42h, and source code 01.
- R5: A carry out of any 8-bit checksum addition is added back into the sum before the comparison. A stored value computed without this fold is rejected.
- R6: After a rejected word 05h, no further EEPROM reads take place. The fuse array is read once, bytes 0 to 63, and a requested byte is returned in the cycle after the request. The fuse is accepted when the stored byte at index 50 (fuse word 19h, low byte) equals 0xFF minus the sum of the other 63 bytes. When it is accepted, the outputs are set as follows: node address from bytes 0–5, vendor ID from bytes 6/7 (low/high), product ID from bytes 8/9, flags from byte 49 (word 18h, high byte), LED mode from bytes 52/53, and source code 10.
- R7: A fuse array whose byte 0 is 0xFF is rejected even when its checksum is correct.
- R8: If both sources are rejected, the outputs take the built-in values: node 00-0E-C6-81-78-01, vendor ID 0F1Eh, product ID 178Ah, flags 00h, LED mode 0000h, and source code 11.
- R9: `done_o` is low and the source code is 00 until loading finishes. After that, `done_o` stays high and every field output holds its value until reset.
- R10: No fuse read is requested once `done_o` is high. The EEPROM lines are never enabled while the fuse is being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_sck_o | output | 1 | EEPROM serial clock |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_ctl_oe_o | output | 1 | Output enable for the clock and chip-select pads |
| ee_dio_o | output | 1 | Command bit sent to the EEPROM |
| ee_dio_oe_o | output | 1 | Output enable for the data pad |
| ee_dio_i | input | 1 | Data pad input |
| fuse_rd_o | output | 1 | Fuse byte read request |
| fuse_addr_o | output | 6 | Fuse byte index |
| fuse_data_i | input | 8 | Fuse byte, valid in the cycle after the request |
| node_addr_o | output | 48 | Node address, first octet in bits 47:40 |
| vid_o | output | 16 | Vendor ID |
| pid_o | output | 16 | Product ID |
| flags_o | output | 8 | Flag byte |
| led_mode_o | output | 16 | LED mode word |
| src_o | output | 2 | Source used: 00 none yet, 01 EEPROM, 10 fuse, 11 defaults |
| done_o | output | 1 | Loading complete |

## Verification
On every cycle, the assertions check the serial bus discipline and the handover between the two sources. The data bit holds steady while the clock is high, and chip select never rises during a high clock phase. The pads are released when chip select drops, and the EEPROM is never driven during fuse reads. Once `done_o` is high, it stays high and the outputs stay frozen. Whether a given source is accepted or rejected shows only in the bench scenarios. Those scenarios cover a good EEPROM, checksums with and without the end-around carry, a missing EEPROM, a fuse with byte 0 set to 0xFF, and a corrupted fuse checksum. The bench compares the fields, the source code and the sequence of word addresses against its own model.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EE   = 2'd1,
    SRC_FUSE = 2'd2,
    SRC_DEF  = 2'd3
  } cfg_src_e;

  localparam logic [47:0] DEF_NODE  = 48'h000EC6817801;
  localparam logic [15:0] DEF_VID   = 16'h0F1E;
  localparam logic [15:0] DEF_PID   = 16'h178A;
  localparam logic [7:0]  DEF_FLAGS = 8'h00;
  localparam logic [15:0] DEF_LED   = 16'h0000;

  // 8-bit add with end-around carry
  function automatic logic [7:0] ones_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/boot_csum_acc.sv
module boot_csum_acc import boot_cfg_pkg::*; #(
  parameter int LANES = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               add_i,
  input  logic [8*LANES-1:0] data_i,
  output logic [7:0]         sum_o
);
  logic [7:0] sum_q;
  logic [7:0] chain [LANES+1];

  assign chain[0] = sum_q;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chain[g+1] = ones_add(chain[g], data_i[8*g +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (add_i) sum_q <= chain[LANES];
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/boot_ee_reader.sv
module boot_ee_reader #(
  parameter int CLK_DIV = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ee_sck_o,
  output logic              ee_cs_o,
  output logic              ee_ctl_oe_o,
  output logic              ee_dio_o,
  output logic              ee_dio_oe_o,
  input  logic              ee_dio_i
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int DIV_W    = $clog2(CLK_DIV);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int TOT_BITS = CMD_BITS + 1 + DATA_W;
  localparam int BIT_W    = $clog2(TOT_BITS + 1);

  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_st_e;

  rd_st_e              st_q;
  logic [DIV_W-1:0]    div_q;
  logic [BIT_W-1:0]    bit_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [DATA_W-1:0]   data_q;
  logic                valid_q;
  logic                div_end;

  assign div_end = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RD_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        RD_IDLE: if (start_i) begin
          st_q  <= RD_SHIFT;
          div_q <= '0;
          bit_q <= '0;
          cmd_q <= {3'b110, addr_i};
        end
        RD_SHIFT: if (div_end) begin
          div_q <= '0;
          if (bit_q >= BIT_W'(CMD_BITS)) data_q <= {data_q[DATA_W-2:0], ee_dio_i};
          if (bit_q == BIT_W'(TOT_BITS - 1)) st_q <= RD_GAP;
          else begin
            bit_q <= bit_q + 1'b1;
            cmd_q <= cmd_q << 1;
          end
        end else div_q <= div_q + 1'b1;
        RD_GAP: if (div_end) begin
          div_q   <= '0;
          st_q    <= RD_IDLE;
          valid_q <= 1'b1;
        end else div_q <= div_q + 1'b1;
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  assign ee_cs_o     = (st_q == RD_SHIFT);
  assign ee_ctl_oe_o = (st_q == RD_SHIFT);
  assign ee_sck_o    = (st_q == RD_SHIFT) && (div_q >= DIV_W'(HALF));
  assign ee_dio_oe_o = (st_q == RD_SHIFT) && (bit_q < BIT_W'(CMD_BITS));
  assign ee_dio_o    = ee_dio_oe_o & cmd_q[CMD_BITS-1];
  assign valid_o     = valid_q;
  assign data_o      = data_q;

  a_r2_dio_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sck_o |=> (!ee_sck_o || $stable(ee_dio_o)));
  a_r2_cs_rise_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_cs_o) |-> !ee_sck_o);
  a_r3_release_on_cs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ee_cs_o) |-> (!ee_ctl_oe_o && !ee_dio_oe_o && !ee_sck_o));
  a_r3_dio_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_dio_oe_o |-> ee_cs_o);
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader import boot_cfg_pkg::*; #(
  parameter int CLK_DIV       = 32,
  parameter int FUSE_BYTES    = 64,
  parameter int LED_WORD      = 8'h42,
  parameter int FUSE_FLAG_IDX = 49,
  parameter int FUSE_CSUM_IDX = 50,
  parameter int FUSE_LED_IDX  = 52
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        ee_sck_o,
  output logic        ee_cs_o,
  output logic        ee_ctl_oe_o,
  output logic        ee_dio_o,
  output logic        ee_dio_oe_o,
  input  logic        ee_dio_i,
  output logic        fuse_rd_o,
  output logic [5:0]  fuse_addr_o,
  input  logic [7:0]  fuse_data_i,
  output logic [47:0] node_addr_o,
  output logic [15:0] vid_o,
  output logic [15:0] pid_o,
  output logic [7:0]  flags_o,
  output logic [15:0] led_mode_o,
  output logic [1:0]  src_o,
  output logic        done_o
);
  localparam int FA_W = $clog2(FUSE_BYTES);
  localparam int FC_W = FA_W + 1;

  typedef enum logic [2:0] {T_EE_GO, T_EE_WAIT, T_FUSE, T_FUSE_CHK, T_DONE} top_st_e;

  top_st_e     st_q;
  logic [2:0]  step_q;
  logic [7:0]  ee_addr;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [7:0]  ee_sum, fuse_sum;
  logic        ee_ok;
  logic [FC_W-1:0] fcnt_q;
  logic        fv_q;
  logic [FA_W-1:0] fa_q;
  logic        first_ff_q;
  logic [7:0]  fcsum_q;
  logic [47:0] s_node;
  logic [15:0] s_vid, s_pid, s_led;
  logic [7:0]  s_flags;

  always_comb begin
    unique case (step_q)
      3'd0:    ee_addr = 8'h03;
      3'd1:    ee_addr = 8'h04;
      3'd2:    ee_addr = 8'h05;
      3'd3:    ee_addr = 8'h00;
      3'd4:    ee_addr = 8'h01;
      3'd5:    ee_addr = 8'h02;
      default: ee_addr = 8'(LED_WORD);
    endcase
  end

  boot_ee_reader #(.CLK_DIV(CLK_DIV), .ADDR_W(8), .DATA_W(16)) u_rd (
    .clk_i, .rst_ni,
    .start_i    (st_q == T_EE_GO),
    .addr_i     (ee_addr),
    .valid_o    (rd_valid),
    .data_o     (rd_data),
    .ee_sck_o, .ee_cs_o, .ee_ctl_oe_o, .ee_dio_o, .ee_dio_oe_o, .ee_dio_i
  );

  boot_csum_acc #(.LANES(2)) u_ee_sum (
    .clk_i, .rst_ni,
    .add_i  (rd_valid && st_q == T_EE_WAIT && step_q < 3'd2),
    .data_i (rd_data),
    .sum_o  (ee_sum)
  );

  boot_csum_acc #(.LANES(1)) u_fuse_sum (
    .clk_i, .rst_ni,
    .add_i  (fv_q && fa_q != FA_W'(FUSE_CSUM_IDX)),
    .data_i (fuse_data_i),
    .sum_o  (fuse_sum)
  );

  assign ee_ok       = (rd_data[7:0] == 8'hFF - ee_sum);
  assign fuse_rd_o   = (st_q == T_FUSE) && (fcnt_q < FC_W'(FUSE_BYTES));
  assign fuse_addr_o = 6'(fcnt_q[FA_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= T_EE_GO;  step_q <= '0;
      fcnt_q <= '0;  fv_q <= 1'b0;  fa_q <= '0;
      first_ff_q <= 1'b0;  fcsum_q <= '0;
      s_node <= '0;  s_vid <= '0;  s_pid <= '0;  s_led <= '0;  s_flags <= '0;
      node_addr_o <= '0;  vid_o <= '0;  pid_o <= '0;  flags_o <= '0;
      led_mode_o <= '0;  src_o <= SRC_NONE;  done_o <= 1'b0;
    end else begin
      fv_q <= fuse_rd_o;
      fa_q <= fuse_addr_o[FA_W-1:0];
      unique case (st_q)
        T_EE_GO: st_q <= T_EE_WAIT;
        T_EE_WAIT: if (rd_valid) begin
          unique case (step_q)
            3'd0: s_vid <= rd_data;
            3'd1: s_pid <= rd_data;
            3'd2: s_flags <= rd_data[15:8];
            3'd3: s_node[47:32] <= {rd_data[7:0], rd_data[15:8]};
            3'd4: s_node[31:16] <= {rd_data[7:0], rd_data[15:8]};
            3'd5: s_node[15:0]  <= {rd_data[7:0], rd_data[15:8]};
            default: ;
          endcase
          if (step_q == 3'd2 && !ee_ok) st_q <= T_FUSE;
          else if (step_q == 3'd6) begin
            node_addr_o <= s_node;  vid_o <= s_vid;  pid_o <= s_pid;
            flags_o <= s_flags;  led_mode_o <= rd_data;
            src_o <= SRC_EE;  done_o <= 1'b1;  st_q <= T_DONE;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= T_EE_GO;
          end
        end
        T_FUSE: begin
          if (fuse_rd_o) fcnt_q <= fcnt_q + 1'b1;
          if (fv_q) begin
            if (fa_q == '0) first_ff_q <= (fuse_data_i == 8'hFF);
            if (fa_q < FA_W'(6)) s_node[8*(5-int'(fa_q)) +: 8] <= fuse_data_i;
            if (fa_q == FA_W'(6)) s_vid[7:0]  <= fuse_data_i;
            if (fa_q == FA_W'(7)) s_vid[15:8] <= fuse_data_i;
            if (fa_q == FA_W'(8)) s_pid[7:0]  <= fuse_data_i;
            if (fa_q == FA_W'(9)) s_pid[15:8] <= fuse_data_i;
            if (fa_q == FA_W'(FUSE_FLAG_IDX)) s_flags <= fuse_data_i;
            if (fa_q == FA_W'(FUSE_CSUM_IDX)) fcsum_q <= fuse_data_i;
            if (fa_q == FA_W'(FUSE_LED_IDX))     s_led[7:0]  <= fuse_data_i;
            if (fa_q == FA_W'(FUSE_LED_IDX + 1)) s_led[15:8] <= fuse_data_i;
            if (fa_q == FA_W'(FUSE_BYTES - 1)) st_q <= T_FUSE_CHK;
          end
        end
        T_FUSE_CHK: begin
          if (!first_ff_q && fcsum_q == 8'hFF - fuse_sum) begin
            node_addr_o <= s_node;  vid_o <= s_vid;  pid_o <= s_pid;
            flags_o <= s_flags;  led_mode_o <= s_led;  src_o <= SRC_FUSE;
          end else begin
            node_addr_o <= DEF_NODE;  vid_o <= DEF_VID;  pid_o <= DEF_PID;
            flags_o <= DEF_FLAGS;  led_mode_o <= DEF_LED;  src_o <= SRC_DEF;
          end
          done_o <= 1'b1;
          st_q   <= T_DONE;
        end
        default: st_q <= T_DONE;
      endcase
    end
  end

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r9_fields_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(node_addr_o) && $stable(vid_o) && $stable(pid_o) &&
                $stable(flags_o) && $stable(led_mode_o) && $stable(src_o)));
  a_r9_src_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (src_o != 2'b00));
  a_r10_no_fuse_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fuse_rd_o);
  a_r10_ee_quiet_in_fuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_rd_o |-> (!ee_ctl_oe_o && !ee_dio_oe_o));
  a_r3_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ee_ctl_oe_o && !ee_cs_o));
endmodule

// File: tb/tb_boot_cfg_loader.sv
module tb_boot_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 32;
  localparam int HALF       = CLK_DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ee_sck_o, ee_cs_o, ee_ctl_oe_o, ee_dio_o, ee_dio_oe_o, ee_dio_i;
  logic fuse_rd_o;
  logic [5:0] fuse_addr_o;
  logic [7:0] fuse_data_i = '0;
  logic [47:0] node_addr_o;
  logic [15:0] vid_o, pid_o, led_mode_o;
  logic [7:0] flags_o;
  logic [1:0] src_o;
  logic done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_cfg_loader #(.CLK_DIV(CLK_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ee_sck_o, .ee_cs_o, .ee_ctl_oe_o, .ee_dio_o, .ee_dio_oe_o, .ee_dio_i,
    .fuse_rd_o, .fuse_addr_o, .fuse_data_i,
    .node_addr_o, .vid_o, .pid_o, .flags_o, .led_mode_o, .src_o, .done_o
  );

  int checks = 0, failures = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fold(input int s);
    int t = s;
    while (t > 255) t = (t & 255) + (t >> 8);
    return 8'(t);
  endfunction

  // EEPROM model
  logic [15:0] ee_mem [256];
  logic ee_present = 1'b1;
  int ee_n = 0;
  logic [10:0] ee_cmd = '0;
  logic [15:0] ee_word = '0;
  logic ee_do = 1'b1;
  int ee_log[$];
  assign ee_dio_i = ee_dio_oe_o ? ee_dio_o : (ee_present ? ee_do : 1'b1);

  always @(posedge ee_sck_o or negedge ee_cs_o) begin
    if (!ee_cs_o) ee_n = 0;
    else begin
      if (ee_n < 11) begin
        ee_cmd = {ee_cmd[9:0], ee_dio_o};
        if (ee_n == 10) begin
          chk("R1 start+opcode", 64'(ee_cmd[10:8]), 64'(3'b110));
          ee_log.push_back(int'(ee_cmd[7:0]));
          ee_word = ee_mem[ee_cmd[7:0]];
        end
      end else if (ee_n == 11) ee_do = 1'b0;
      else if (ee_n <= 27) ee_do = ee_word[27-ee_n];
      ee_n++;
    end
  end

  // fuse model
  logic [7:0] fuse_mem [64];
  int fuse_reads = 0;
  always @(posedge clk) if (fuse_rd_o) begin
    fuse_data_i <= fuse_mem[fuse_addr_o];
    fuse_reads++;
  end

  // reference expectation and per-clock comparison
  logic [1:0]  e_src;
  logic [47:0] e_node;
  logic [15:0] e_vid, e_pid, e_led;
  logic [7:0]  e_flags;
  logic seen_done = 1'b0;
  int hi_run = 0;
  logic prev_sck = 1'b0, prev_dio = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (ee_sck_o) hi_run++;
    else if (hi_run != 0) begin
      chk("R2 sck high width", 64'(hi_run), 64'(HALF));
      hi_run = 0;
    end
    if (ee_sck_o && prev_sck && ee_dio_oe_o) chk("R2 dio steady while sck high", 64'(ee_dio_o), 64'(prev_dio));
    prev_sck = ee_sck_o; prev_dio = ee_dio_o;
    if (!ee_cs_o) chk("R3 released without cs", 64'({ee_ctl_oe_o, ee_dio_oe_o, ee_sck_o}), 64'(0));
    if (seen_done) chk("R9 done stays high", 64'(done_o), 64'(1));
    if (!done_o) chk("R9 source before done", 64'(src_o), 64'(0));
    else begin
      seen_done = 1'b1;
      chk("R9 source", 64'(src_o), 64'(e_src));
      chk("R9 fields", {node_addr_o, vid_o}, {e_node, e_vid});
      chk("R9 more fields", 64'({pid_o, flags_o, led_mode_o}), 64'({e_pid, e_flags, e_led}));
      chk("R10 no fuse read after done", 64'(fuse_rd_o), 64'(0));
    end
    if (fuse_rd_o) chk("R10 EEPROM idle in fuse phase", 64'(ee_ctl_oe_o), 64'(0));
  end

  task automatic ee_build(input logic [47:0] node, input logic [15:0] w3, input logic [15:0] w4,
                          input logic [7:0] flags, input logic [15:0] led, input bit no_fold);
    int raw;
    for (int i = 0; i < 256; i++) ee_mem[i] = 16'hFFFF;
    ee_mem[0] = {node[39:32], node[47:40]};
    ee_mem[1] = {node[23:16], node[31:24]};
    ee_mem[2] = {node[7:0], node[15:8]};
    ee_mem[3] = w3; ee_mem[4] = w4;
    raw = w3[7:0] + w3[15:8] + w4[7:0] + w4[15:8];
    ee_mem[5] = {flags, no_fold ? 8'hFF - 8'(raw) : 8'hFF - fold(raw)};
    ee_mem[8'h42] = led;
    ee_present = 1'b1;
  endtask

  task automatic fuse_build(input logic [47:0] node, input bit first_ff, input bit bad_sum);
    int s = 0;
    for (int i = 0; i < 64; i++) fuse_mem[i] = 8'(i * 37 + 5);
    for (int i = 0; i < 6; i++) fuse_mem[i] = node[8*(5-i) +: 8];
    if (first_ff) fuse_mem[0] = 8'hFF;
    for (int i = 0; i < 64; i++) if (i != 50) s += fuse_mem[i];
    fuse_mem[50] = (8'hFF - fold(s)) ^ (bad_sum ? 8'h01 : 8'h00);
  endtask

  task automatic expect_fuse();
    e_src = 2'b10;
    e_node = {fuse_mem[0], fuse_mem[1], fuse_mem[2], fuse_mem[3], fuse_mem[4], fuse_mem[5]};
    e_vid = {fuse_mem[7], fuse_mem[6]}; e_pid = {fuse_mem[9], fuse_mem[8]};
    e_flags = fuse_mem[49]; e_led = {fuse_mem[53], fuse_mem[52]};
  endtask

  task automatic expect_default();
    e_src = 2'b11; e_node = 48'h000EC6817801; e_vid = 16'h0F1E; e_pid = 16'h178A;
    e_flags = 8'h00; e_led = 16'h0000;
  endtask

  task automatic run(input string tag, input int exp_words, input int exp_fuse);
    int ord[7] = '{3, 4, 5, 0, 1, 2, 66};
    int n;
    ee_log.delete(); fuse_reads = 0; seen_done = 1'b0; hi_run = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " R9 reset done/src"}, 64'({done_o, src_o}), 64'(0));
    chk({tag, " R3 reset pads"}, 64'({ee_ctl_oe_o, ee_dio_oe_o, fuse_rd_o}), 64'(0));
    rst_n = 1'b1;
    n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    chk({tag, " R9 done reached"}, 64'(done_o), 64'(1));
    repeat (4) @(negedge clk);
    chk({tag, " R1/R6 EEPROM word count"}, 64'(ee_log.size()), 64'(exp_words));
    for (int i = 0; i < ee_log.size() && i < 7; i++)
      chk({tag, " R1 word order"}, 64'(ee_log[i]), 64'(ord[i]));
    chk({tag, " R6 fuse byte reads"}, 64'(fuse_reads), 64'(exp_fuse));
    chk({tag, " R4/R6/R8 source"}, 64'(src_o), 64'(e_src));
    chk({tag, " R4/R6/R8 node"}, 64'(node_addr_o), 64'(e_node));
    chk({tag, " R4/R6/R8 ids"}, 64'({vid_o, pid_o}), 64'({e_vid, e_pid}));
    chk({tag, " R4/R6/R8 flags+led"}, 64'({flags_o, led_mode_o}), 64'({e_flags, e_led}));
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R4: valid EEPROM, sum carries
    ee_build(48'h021122334455, 16'hA1B2, 16'hC3D4, 8'h5A, 16'h0C3F, 1'b0);
    fuse_build(48'h0A0B0C0D0E0F, 1'b0, 1'b0);
    e_src = 2'b01; e_node = 48'h021122334455; e_vid = 16'hA1B2; e_pid = 16'hC3D4;
    e_flags = 8'h5A; e_led = 16'h0C3F;
    run("S1", 7, 0);
    // R5: folded checksum accepted
    ee_build(48'h0C0000ABCDEF, 16'h20F0, 16'h0201, 8'h81, 16'h7E01, 1'b0);
    e_src = 2'b01; e_node = 48'h0C0000ABCDEF; e_vid = 16'h20F0; e_pid = 16'h0201;
    e_flags = 8'h81; e_led = 16'h7E01;
    run("S2 R5 fold", 7, 0);
    // R5: unfolded value rejected -> R6 fuse
    ee_build(48'h0C0000ABCDEF, 16'h20F0, 16'h0201, 8'h81, 16'h7E01, 1'b1);
    expect_fuse();
    run("S3 R5 nofold", 3, 64);
    // R6: absent EEPROM, valid fuse
    ee_present = 1'b0;
    fuse_build(48'h00C0FFEE0001, 1'b0, 1'b0);
    expect_fuse();
    run("S4 R6", 3, 64);
    // R7: byte 0 = FF
    fuse_build(48'hFF1122334455, 1'b1, 1'b0);
    expect_default();
    run("S5 R7", 3, 64);
    // R8: bad fuse checksum
    fuse_build(48'h001122334455, 1'b0, 1'b1);
    expect_default();
    run("S6 R8", 3, 64);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule